// File: doc/BRIEF.md
# Segment Selector Load and Linear Address Translation

This block keeps a small bank of segment registers. Each register has two parts. The first is a 16-bit selector that software can see. The second is a hidden 32-bit base that the block fetches from memory once, at the moment a selector is loaded. A load request names a register and a selector value. The block splits the selector into a descriptor index, a table-choice bit and a requested privilege level. It uses the table-choice bit to pick either the global or the local descriptor table base. It then forms the descriptor's byte address and sends one read on a simple request/response memory port. The returned word is written into the hidden base of the register that was loaded.

A memory reference names a register and a 32-bit offset. The block adds the cached base to the offset, so an ordinary reference needs only one addition and no table lookup. Only one load can be in flight at a time. References to the register that is being reloaded are held off until the read returns. References to the other registers go ahead during the load. With paging off, the linear address produced here is used unchanged as the physical address.

Top module: `seg_xlat`

## Requirements
- R1: During reset and after it, every selector reads 0 and every hidden base is 0. mem_req and lin_valid are low. Two cycles after rst_n rises, ld_ready and ref_ready are high.
- R2: A selector is laid out with the index in bits 15:3, the table-choice bit in bit 2 and the privilege level in bits 1:0. A load is accepted on a clock edge where ld_valid and ld_ready are both high. From the next cycle, the full 16-bit value reads back on rd_sel when rd_reg selects that register.
- R3: The descriptor address on mem_addr is the table base plus the index times 8, modulo 2^32. The table base is gdt_base when bit 2 is 0 and ldt_base when bit 2 is 1. Bits 1:0 have no effect on the address.
- R4: mem_req is high for exactly one cycle, the cycle after a load is accepted, and mem_addr is valid in that cycle.
- R5: Only one load is in flight at a time. ld_ready is low from the cycle after a load is accepted until the cycle after a response is accepted.
- R6: A response is accepted on a clock edge where mem_rvalid is high and a load is in flight, including the mem_req cycle itself. mem_rdata is then written only to the hidden base of the register being loaded.
- R7: ref_ready is low for the register being loaded, from the cycle after the load is accepted until the response is accepted. A reference to that register is not taken while ref_ready is low. References to the other registers are accepted during the load.
- R8: A reference is accepted on a clock edge where ref_valid and ref_ready are both high. In the next cycle, lin_valid is high and lin_addr equals the hidden base plus ref_off, modulo 2^32. In every other cycle, lin_valid is low.
- R9: A load and a reference may both be accepted on the same edge for the same register. In that case the reference uses the base that was in place before the load.
- R10: mem_rvalid has no effect while no load is in flight. No hidden base changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gdt_base | input | 32 | Global descriptor table base address |
| ldt_base | input | 32 | Local descriptor table base address |
| ld_valid | input | 1 | Selector load request |
| ld_reg | input | 2 | Segment register to load |
| ld_sel | input | 16 | Selector value to load |
| ld_ready | output | 1 | High when a load can be accepted |
| rd_reg | input | 2 | Register whose selector is shown on rd_sel |
| rd_sel | output | 16 | Visible selector of the register chosen by rd_reg |
| mem_req | output | 1 | Descriptor read request, one cycle wide |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Segment base returned by memory |
| ref_valid | input | 1 | Memory reference request |
| ref_reg | input | 2 | Segment register the reference uses |
| ref_off | input | 32 | Offset address |
| ref_ready | output | 1 | High when the reference can be accepted |
| lin_valid | output | 1 | Linear address valid |
| lin_addr | output | 32 | Linear address (the physical address when paging is off) |

## Verification
Two functions can meet in the same cycle. The first is a load and a reference to the same register. The bench drives both on one edge and requires that the linear address uses the base from before the load. The second is a response arriving in the very cycle that the request is issued. The bench returns mem_rvalid at zero delay and also after several wait cycles. While a response is pending, it drives references to the busy register and to the other registers, and checks which ones are taken.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2
  } ld_state_e;
endpackage

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] gdt_base,
  input  logic [AW-1:0] ldt_base,
  output logic [AW-1:0] desc_addr
);
  localparam int IW = SW - 3;

  logic [IW-1:0] idx;
  logic          tbl_local;
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] byte_off;

  always_comb begin
    idx       = sel[SW-1:3];
    tbl_local = sel[2];
    tbl_base  = tbl_local ? ldt_base : gdt_base;
    byte_off  = AW'({idx, 3'b000});
    desc_addr = tbl_base + byte_off;
  end
endmodule

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int SW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic [RW-1:0] sel_idx,
  input  logic [SW-1:0] sel_wdata,
  input  logic          base_we,
  input  logic [RW-1:0] base_idx,
  input  logic [AW-1:0] base_wdata,
  input  logic [RW-1:0] rd_idx,
  output logic [SW-1:0] rd_sel,
  input  logic [RW-1:0] ref_idx,
  output logic [AW-1:0] ref_base
);
  logic [SW-1:0] sel_q  [NREG];
  logic [AW-1:0] base_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_seg
    logic sel_en;
    logic base_en;
    assign sel_en  = sel_we  && (sel_idx  == RW'(g));
    assign base_en = base_we && (base_idx == RW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g] <= '0;
      end else if (sel_en) begin
        sel_q[g] <= sel_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
      end else if (base_en) begin
        base_q[g] <= base_wdata;
      end
    end
  end

  assign rd_sel   = sel_q[rd_idx];
  assign ref_base = base_q[ref_idx];
endmodule

// File: rtl/lin_adder.sv
module lin_adder #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] off,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);
  logic [AW-1:0] sum_d;

  always_comb sum_d = base + off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
    end else if (in_valid) begin
      out_addr <= sum_d;
    end
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int SW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] gdt_base,
  input  logic [AW-1:0] ldt_base,
  input  logic          ld_valid,
  input  logic [RW-1:0] ld_reg,
  input  logic [SW-1:0] ld_sel,
  output logic          ld_ready,
  input  logic [RW-1:0] rd_reg,
  output logic [SW-1:0] rd_sel,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  input  logic          ref_valid,
  input  logic [RW-1:0] ref_reg,
  input  logic [AW-1:0] ref_off,
  output logic          ref_ready,
  output logic          lin_valid,
  output logic [AW-1:0] lin_addr
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rsync_q[1];

  ld_state_e     state_q, state_d;
  logic [RW-1:0] pend_q,  pend_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic [AW-1:0] desc_addr;
  logic [AW-1:0] ref_base;
  logic          ld_fire, rsp_fire, ref_fire, in_flight;

  sel_decode #(.AW(AW), .SW(SW)) i_dec (
    .sel       (ld_sel),
    .gdt_base  (gdt_base),
    .ldt_base  (ldt_base),
    .desc_addr (desc_addr)
  );

  always_comb begin
    in_flight = (state_q != LD_IDLE);
    ld_ready  = rst_s_n && !in_flight;
    ref_ready = rst_s_n && !(in_flight && (pend_q == ref_reg));
    ld_fire   = ld_valid && ld_ready;
    rsp_fire  = mem_rvalid && in_flight;
    ref_fire  = ref_valid && ref_ready;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    unique case (state_q)
      LD_IDLE: if (ld_fire) begin
        state_d = LD_REQ;
        pend_d  = ld_reg;
        addr_d  = desc_addr;
      end
      LD_REQ:  state_d = rsp_fire ? LD_IDLE : LD_WAIT;
      LD_WAIT: if (rsp_fire) state_d = LD_IDLE;
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= LD_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      addr_q  <= addr_d;
    end
  end

  assign mem_req  = (state_q == LD_REQ);
  assign mem_addr = addr_q;

  seg_bank #(.NREG(NREG), .AW(AW), .SW(SW)) i_bank (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .sel_we     (ld_fire),
    .sel_idx    (ld_reg),
    .sel_wdata  (ld_sel),
    .base_we    (rsp_fire),
    .base_idx   (pend_q),
    .base_wdata (mem_rdata),
    .rd_idx     (rd_reg),
    .rd_sel     (rd_sel),
    .ref_idx    (ref_reg),
    .ref_base   (ref_base)
  );

  lin_adder #(.AW(AW)) i_add (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .in_valid  (ref_fire),
    .base      (ref_base),
    .off       (ref_off),
    .out_valid (lin_valid),
    .out_addr  (lin_addr)
  );
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int AW = 32,
  parameter int RW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic [RW-1:0] ld_reg,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic          ref_valid,
  input logic          ref_ready,
  input logic [RW-1:0] ref_reg,
  input logic [AW-1:0] ref_base,
  input logic [AW-1:0] ref_off,
  input logic          lin_valid,
  input logic [AW-1:0] lin_addr
);
  logic          ck_busy;
  logic [RW-1:0] ck_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_busy <= 1'b0;
      ck_pend <= '0;
    end else if (ld_valid && ld_ready) begin
      ck_busy <= 1'b1;
      ck_pend <= ld_reg;
    end else if (mem_rvalid && ck_busy) begin
      ck_busy <= 1'b0;
    end
  end

  a_r4_req_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> mem_req);
  a_r4_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r5_busy_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    ck_busy |-> !ld_ready);
  a_r5_idle_allows_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_busy |-> ld_ready);
  a_r7_busy_reg_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_busy && (ref_reg == ck_pend)) |-> !ref_ready);
  a_r7_other_reg_flows: assert property (@(posedge clk) disable iff (!rst_n)
    !(ck_busy && (ref_reg == ck_pend)) |-> ref_ready);
  a_r8_valid_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready) |=> (lin_valid && (lin_addr == $past(ref_base) + $past(ref_off))));
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_valid && ref_ready) |=> !lin_valid);
endmodule

bind seg_xlat seg_xlat_chk #(.AW(AW), .RW(RW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .ld_valid   (ld_valid),
  .ld_ready   (ld_ready),
  .ld_reg     (ld_reg),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .ref_valid  (ref_valid),
  .ref_ready  (ref_ready),
  .ref_reg    (ref_reg),
  .ref_base   (ref_base),
  .ref_off    (ref_off),
  .lin_valid  (lin_valid),
  .lin_addr   (lin_addr)
);

// File: tb/test_seg_xlat.sv
module test_seg_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] gdt_base = '0, ldt_base = '0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_reg = '0;
  logic [15:0] ld_sel = '0;
  logic        ld_ready;
  logic [1:0]  rd_reg = '0;
  logic [15:0] rd_sel;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ref_valid = 1'b0;
  logic [1:0]  ref_reg = '0;
  logic [31:0] ref_off = '0;
  logic        ref_ready;
  logic        lin_valid;
  logic [31:0] lin_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_base [4];
  logic [15:0] exp_sel  [4];

  always #4 clk = ~clk;

  seg_xlat i_seg_xlat (
    .clk(clk), .rst_n(rst_n), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_sel(ld_sel), .ld_ready(ld_ready),
    .rd_reg(rd_reg), .rd_sel(rd_sel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ref_valid(ref_valid),
    .ref_reg(ref_reg), .ref_off(ref_off), .ref_ready(ref_ready),
    .lin_valid(lin_valid), .lin_addr(lin_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference: accept, then check the registered sum one cycle later
  task automatic do_ref(input logic [1:0] r, input logic [31:0] off);
    @(negedge clk);
    ref_valid = 1'b1; ref_reg = r; ref_off = off;
    check(ref_ready == 1'b1, "R7 ref_ready idle", {31'b0, ref_ready}, 32'd1);
    @(negedge clk);
    ref_valid = 1'b0;
    check(lin_valid == 1'b1, "R8 lin_valid", {31'b0, lin_valid}, 32'd1);
    check(lin_addr == exp_base[r] + off, "R8 lin_addr", lin_addr, exp_base[r] + off);
    @(negedge clk);
    check(lin_valid == 1'b0, "R8 lin_valid drop", {31'b0, lin_valid}, 32'd0);
  endtask

  task automatic do_load(input logic [1:0] r, input logic [15:0] sel,
                         input logic [31:0] base, input int delay);
    logic [31:0] ea;
    ea = (sel[2] ? ldt_base : gdt_base) + {16'b0, sel[15:3], 3'b000};
    @(negedge clk);
    ld_valid = 1'b1; ld_reg = r; ld_sel = sel;
    check(ld_ready == 1'b1, "R5 ld_ready before", {31'b0, ld_ready}, 32'd1);
    @(negedge clk);
    ld_valid = 1'b0;
    rd_reg = r; ref_reg = r;
    #0;
    check(mem_req == 1'b1, "R4 mem_req", {31'b0, mem_req}, 32'd1);
    check(mem_addr == ea, "R3 mem_addr", mem_addr, ea);
    check(rd_sel == sel, "R2 rd_sel", {16'b0, rd_sel}, {16'b0, sel});
    check(ld_ready == 1'b0, "R5 ld_ready busy", {31'b0, ld_ready}, 32'd0);
    check(ref_ready == 1'b0, "R7 ref_ready busy", {31'b0, ref_ready}, 32'd0);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      check(mem_req == 1'b0, "R4 mem_req single", {31'b0, mem_req}, 32'd0);
      check(ld_ready == 1'b0, "R5 ld_ready wait", {31'b0, ld_ready}, 32'd0);
    end
    mem_rvalid = 1'b1; mem_rdata = base;
    @(negedge clk);
    mem_rvalid = 1'b0;
    check(ld_ready == 1'b1, "R5 ld_ready after", {31'b0, ld_ready}, 32'd1);
    exp_base[r] = base; exp_sel[r] = sel;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin exp_base[i] = '0; exp_sel[i] = '0; end
    gdt_base = 32'h0001_0000; ldt_base = 32'hFFFF_F000;
    repeat (3) @(negedge clk);
    check(mem_req == 1'b0 && lin_valid == 1'b0, "R1 outputs in reset", {30'b0, mem_req, lin_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ld_ready == 1'b1 && ref_ready == 1'b1, "R1 ready after reset", {30'b0, ld_ready, ref_ready}, 32'd3);
    for (int r = 0; r < 4; r++) begin
      rd_reg = 2'(r); #1;
      check(rd_sel == 16'h0, "R1 selector reset", {16'b0, rd_sel}, 32'd0);
      do_ref(2'(r), 32'h0000_1234);
    end

    // sweep: every register, both tables, every privilege level, several indices
    for (int r = 0; r < 4; r++)
      for (int t = 0; t < 2; t++)
        for (int p = 0; p < 4; p++)
          for (int k = 0; k < 3; k++) begin
            logic [12:0] idx;
            idx = (k == 0) ? 13'h0000 : (k == 1) ? 13'h1FFF : 13'(r * 37 + p * 5 + 1);
            do_load(2'(r), {idx, 1'(t), 2'(p)}, 32'h8000_0000 ^ {idx, 3'(r), 16'(k * 4 + p)}, (r + p + k) % 4);
            for (int q = 0; q < 4; q++) do_ref(2'(q), 32'hFFFF_FFF0 + 32'(q));  // R6 others unchanged, R8 wrap
          end

    // R7: reference to another register while a load is pending
    @(negedge clk);
    ld_valid = 1'b1; ld_reg = 2'd1; ld_sel = 16'h0028;
    @(negedge clk);
    ld_valid = 1'b0;
    ref_valid = 1'b1; ref_reg = 2'd2; ref_off = 32'h100;
    @(negedge clk);
    check(lin_valid == 1'b1 && lin_addr == exp_base[2] + 32'h100, "R7 other reg flows", lin_addr, exp_base[2] + 32'h100);
    ref_reg = 2'd1;
    @(negedge clk);
    check(lin_valid == 1'b0, "R7 busy reg held", {31'b0, lin_valid}, 32'd0);
    ref_valid = 1'b0;
    mem_rvalid = 1'b1; mem_rdata = 32'h1357_9BDF;
    @(negedge clk);
    mem_rvalid = 1'b0; exp_base[1] = 32'h1357_9BDF;
    do_ref(2'd1, 32'h2);

    // R9: load and reference to the same register on one edge
    @(negedge clk);
    ld_valid = 1'b1; ld_reg = 2'd0; ld_sel = 16'h0010;
    ref_valid = 1'b1; ref_reg = 2'd0; ref_off = 32'h44;
    @(negedge clk);
    ld_valid = 1'b0; ref_valid = 1'b0;
    check(lin_valid == 1'b1 && lin_addr == exp_base[0] + 32'h44, "R9 old base used", lin_addr, exp_base[0] + 32'h44);
    mem_rvalid = 1'b1; mem_rdata = 32'hABCD_0000;
    @(negedge clk);
    mem_rvalid = 1'b0; exp_base[0] = 32'hABCD_0000;
    do_ref(2'd0, 32'h44);

    // R10: stray response while idle
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    mem_rvalid = 1'b0;
    check(ld_ready == 1'b1, "R10 stays idle", {31'b0, ld_ready}, 32'd1);
    for (int q = 0; q < 4; q++) do_ref(2'(q), 32'h10);  // R10 bases unchanged

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule